// File: doc/BRIEF.md
# Serial Configuration Bitstream Reader

This block is the read side of a serial configuration memory. After its bit address counter is cleared, it sends one stored bit per clock to a downstream FPGA. The data bit comes with a separate drive-enable, so a tri-state pad can be built outside the block. An active-low cascade output hands the shared data line to the next memory in a chain once this device has sent its last bit.

An active-low reset/output-enable input clears the counter and releases the data line, whatever the chip enable is doing. The active-low chip enable gates counting and driving while reset/output-enable is high. A serial-mode input chooses between streaming and programming. In programming mode a simple load port fills the bit array, and nothing is streamed. In streaming mode a page-mode input can split the array into four equal windows, and a two-bit select chooses which window is sent. Without page mode the whole array is one bitstream.

Top module: `cfg_stream_reader`

## Requirements
- R1: During the synchronous active-high `rst`, and after it, `dout_oe` is 0 and `cascade_n` is 1. The counter then sits at address 0, and the window is the whole array.
- R2: On every clock edge where `oe_rst_n` is 0, the counter returns to the first address of the window, the end-of-data condition is cleared, and after that edge `dout_oe` is 0 and `cascade_n` is 1. This holds for either value of `ce_n`.
- R3: While `oe_rst_n` is 1 and `ce_n` is 1, the counter holds its value and `dout_oe` is 0 after each edge. When `ce_n` returns to 0, the stream continues from the held address, with no bit lost or repeated.
- R4: While `oe_rst_n`=1, `ce_n`=0 and `ser_en`=1, each rising edge presents the array bit at the current address on `dout` with `dout_oe`=1, and moves the counter to the next address.
- R5: With page mode off at the last clear edge, the stream is array addresses 0 up to DEPTH-1, in ascending order.
- R6: With `page_en`=1 and `ser_en`=1 at the last clear edge, the window is page `page_sel` (0 to 3), of DEPTH/4 bits starting at `page_sel`*DEPTH/4. The page inputs are sampled only on edges where `oe_rst_n` is 0, and are ignored while streaming.
- R7: On the edge after the last bit of the window has been presented, `dout_oe` goes to 0 and `cascade_n` goes to 0 together. Both stay there, and the counter stops, until `oe_rst_n` is driven low again. `dout_oe` and a low `cascade_n` are never seen together.
- R8: With `ser_en`=0, `dout_oe` stays 0 and the counter does not advance. A clear during this mode ignores `page_en` and selects the whole array.
- R9: The load port (`ld_we`, `ld_addr`, `ld_bit`) writes a bit into the array only when `ser_en`=0. With `ser_en`=1, writes have no effect on the streamed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; rising edge advances the counter |
| rst | input | 1 | Synchronous active-high power-up reset |
| oe_rst_n | input | 1 | Active-low counter clear and output release |
| ce_n | input | 1 | Active-low chip enable |
| ser_en | input | 1 | 1 selects streaming, 0 selects programming |
| page_en | input | 1 | 1 splits the array into four pages |
| page_sel | input | 2 | Page number used when page mode is on |
| ld_we | input | 1 | Load-port write strobe (programming mode only) |
| ld_addr | input | AW | Load-port bit address |
| ld_bit | input | 1 | Load-port bit value |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Drive enable for the external data pad |
| cascade_n | output | 1 | Active-low enable for the next device in the chain |

## Verification
The hardest state to reach from the ports is a clear that takes place in programming mode with page mode requested. The window must then be the whole array, even though `page_en` and `page_sel` point at a page. To create it, the stimulus lowers `ser_en` and raises `page_en` with page 3 selected, then pulses `oe_rst_n`. It enables the chip while still in programming mode to confirm that nothing is driven, and only then returns to streaming and collects all DEPTH bits. A chip-enable pause in the middle of a page, and a change of page select right after the clear, are also arranged so that a lost, repeated or re-windowed bit shows up in the collected stream.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    localparam int NUM_PAGES = 4;

    // Streaming progress of the address counter.
    typedef enum logic {
        PH_ACTIVE    = 1'b0,
        PH_EXHAUSTED = 1'b1
    } phase_e;

    // Registered view presented to the pad ring.
    typedef struct packed {
        logic data;
        logic drive;
        logic casc_n;
    } pad_t;

    // First bit address of the streaming window.
    function automatic int win_first(input logic page_mode,
                                     input logic [1:0] sel,
                                     input int depth);
        return page_mode ? int'(sel) * (depth / NUM_PAGES) : 0;
    endfunction

    // Final bit address of the streaming window.
    function automatic int win_last(input logic page_mode,
                                    input logic [1:0] sel,
                                    input int depth);
        return page_mode ? win_first(page_mode, sel, depth) + (depth / NUM_PAGES) - 1
                         : depth - 1;
    endfunction

endpackage

// File: rtl/cfg_bit_rom.sv
module cfg_bit_rom #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);

    logic bits_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            bits_q[waddr] <= wbit;
        end
        rbit <= bits_q[raddr];
    end

endmodule

// File: rtl/cfg_addr_ctrl.sv
module cfg_addr_ctrl
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  logic          page_mode,
    input  logic [1:0]    page_sel,
    output logic [AW-1:0] addr,
    output logic          exhausted
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] last_q;
    logic [AW-1:0] first_w;
    logic [AW-1:0] last_w;
    phase_e        ph_q;

    initial begin
        AST_DEPTH_SPLITS: assert (DEPTH % NUM_PAGES == 0 && DEPTH >= NUM_PAGES); // R6
    end

    assign first_w = AW'(win_first(page_mode, page_sel, DEPTH));
    assign last_w  = AW'(win_last(page_mode, page_sel, DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            last_q <= AW'(DEPTH - 1);
            ph_q   <= PH_ACTIVE;
        end else if (clr) begin
            addr_q <= first_w;
            last_q <= last_w;
            ph_q   <= PH_ACTIVE;
        end else if (run && ph_q == PH_ACTIVE) begin
            if (addr_q == last_q) begin
                ph_q <= PH_EXHAUSTED;
            end else begin
                addr_q <= addr_q + AW'(1);
            end
        end
    end

    assign addr      = addr_q;
    assign exhausted = (ph_q == PH_EXHAUSTED);

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!clr && !run) |=> (addr_q == $past(addr_q))); // R3

    AST_END_HELD: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_EXHAUSTED && !clr) |=> (ph_q == PH_EXHAUSTED && addr_q == $past(addr_q))); // R7

    AST_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        addr_q <= last_q); // R6

endmodule

// File: rtl/cfg_pad_stage.sv
module cfg_pad_stage
    import cfg_stream_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic exhausted,
    input  logic rom_bit,
    output pad_t pad
);

    logic drive_q;
    logic casc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
            casc_q  <= 1'b1;
        end else begin
            drive_q <= run && !exhausted;
            casc_q  <= clr || !exhausted;
        end
    end

    assign pad = '{data: rom_bit, drive: drive_q, casc_n: casc_q};

    AST_CASC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !casc_q |-> !drive_q); // R7

    AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!drive_q && casc_q)); // R2

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          oe_rst_n,
    input  logic          ce_n,
    input  logic          ser_en,
    input  logic          page_en,
    input  logic [1:0]    page_sel,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_bit,
    output logic          dout,
    output logic          dout_oe,
    output logic          cascade_n
);

    logic          clr;
    logic          run;
    logic          page_mode;
    logic          load_en;
    logic [AW-1:0] addr;
    logic          exhausted;
    logic          rom_bit;
    pad_t          pad;

    assign clr       = !oe_rst_n;
    assign run       = ser_en && oe_rst_n && !ce_n;
    assign page_mode = ser_en && page_en;
    assign load_en   = !ser_en && ld_we;

    cfg_addr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .run       (run),
        .page_mode (page_mode),
        .page_sel  (page_sel),
        .addr      (addr),
        .exhausted (exhausted)
    );

    cfg_bit_rom #(.DEPTH(DEPTH), .AW(AW)) u_rom (
        .clk   (clk),
        .we    (load_en),
        .waddr (ld_addr),
        .wbit  (ld_bit),
        .raddr (addr),
        .rbit  (rom_bit)
    );

    cfg_pad_stage u_pad (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .run       (run),
        .exhausted (exhausted),
        .rom_bit   (rom_bit),
        .pad       (pad)
    );

    assign dout      = pad.data;
    assign dout_oe   = pad.drive;
    assign cascade_n = pad.casc_n;

    AST_PROG_SILENT: assert property (@(posedge clk) disable iff (rst)
        !ser_en |=> !dout_oe); // R8

    AST_CHIP_OFF: assert property (@(posedge clk) disable iff (rst)
        (oe_rst_n && ce_n) |=> !dout_oe); // R3

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!dout_oe && cascade_n)); // R1

endmodule

// File: tb/cfg_stream_reader_bench.sv
module cfg_stream_reader_bench;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int Q     = DEPTH / 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          oe_rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          ser_en = 1'b1;
    logic          page_en = 1'b0;
    logic [1:0]    page_sel = 2'd0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_bit = 1'b0;
    logic          dout;
    logic          dout_oe;
    logic          cascade_n;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH)) u_cfg_stream_reader (
        .clk(clk), .rst(rst), .oe_rst_n(oe_rst_n), .ce_n(ce_n), .ser_en(ser_en),
        .page_en(page_en), .page_sel(page_sel), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .dout(dout), .dout_oe(dout_oe), .cascade_n(cascade_n)
    );

    function automatic bit pat(int i);
        return bit'(((((i * 13) + 5) >> 2) ^ (i >> 4) ^ i) & 1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, updated on each rising edge.
    int m_addr = 0;
    int m_last = DEPTH - 1;
    bit m_done = 0;
    bit m_oe   = 0;
    bit m_casc = 1;
    bit m_dout = 0;
    bit m_mem [DEPTH];

    always @(posedge clk) begin
        bit go;
        bit pm;
        go = ser_en && oe_rst_n && !ce_n;
        if (rst) begin
            m_addr = 0; m_last = DEPTH - 1; m_done = 0; m_oe = 0; m_casc = 1;
        end else begin
            m_dout = m_mem[m_addr];
            m_oe   = go && !m_done;
            m_casc = !oe_rst_n || !m_done;
            if (!oe_rst_n) begin
                pm     = ser_en && page_en;
                m_addr = pm ? int'(page_sel) * Q : 0;
                m_last = pm ? m_addr + Q - 1 : DEPTH - 1;
                m_done = 0;
            end else if (go && !m_done) begin
                if (m_addr == m_last) m_done = 1;
                else m_addr = m_addr + 1;
            end
            if (!ser_en && ld_we) m_mem[ld_addr] = ld_bit;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(dout_oe === m_oe, cur_req, "model dout_oe", int'(dout_oe), int'(m_oe));
            check(cascade_n === m_casc, cur_req, "model cascade_n", int'(cascade_n), int'(m_casc));
            if (m_oe) check(dout === m_dout, cur_req, "model dout", int'(dout), int'(m_dout));
        end
    end

    task automatic collect(ref bit q[$], input int limit);
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (dout_oe) q.push_back(dout);
            if (!cascade_n) break;
        end
    endtask

    task automatic compare_stream(ref bit q[$], input int first, input int count,
                                  input string req);
        check(q.size() == count, req, "stream length", q.size(), count);
        for (int i = 0; i < count && i < q.size(); i++) begin
            check(q[i] == pat(first + i), req, $sformatf("stream bit %0d", first + i),
                  int'(q[i]), int'(pat(first + i)));
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        bit q[$];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after power-up reset
        check(dout_oe == 1'b0, "R1", "dout_oe after reset", int'(dout_oe), 0);
        check(cascade_n == 1'b1, "R1", "cascade_n after reset", int'(cascade_n), 1);

        // R9: fill array in programming mode
        cur_req = "R9";
        ser_en  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            ld_we = 1'b1; ld_addr = AW'(i); ld_bit = pat(i);
            @(negedge clk);
        end
        // R9: writes while streaming must be ignored
        ser_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            ld_we = 1'b1; ld_addr = AW'(i); ld_bit = !pat(i);
            @(negedge clk);
        end
        ld_we = 1'b0;

        // R5 / R4: whole-array stream
        cur_req = "R5"; page_en = 1'b0; oe_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b0; oe_rst_n = 1'b1;
        q.delete();
        collect(q, 200);
        compare_stream(q, 0, DEPTH, "R5");
        // R7: handoff after last bit
        check(cascade_n == 1'b0, "R7", "cascade_n at end", int'(cascade_n), 0);
        check(dout_oe == 1'b0, "R7", "dout_oe at end", int'(dout_oe), 0);
        cur_req = "R7";
        repeat (5) @(negedge clk);
        check(cascade_n == 1'b0 && dout_oe == 1'b0, "R7", "end state held",
              int'({cascade_n, dout_oe}), 0);

        // R6: page 2, select changed right after the clear
        cur_req = "R6"; page_en = 1'b1; page_sel = 2'd2; oe_rst_n = 1'b0;
        @(negedge clk);
        oe_rst_n = 1'b1; page_sel = 2'd0;
        q.delete();
        collect(q, 100);
        compare_stream(q, 2 * Q, Q, "R6");
        check(cascade_n == 1'b0, "R6", "cascade_n at page end", int'(cascade_n), 0);

        // R2: clear with chip disabled, then start page 1
        cur_req = "R2"; ce_n = 1'b1; page_sel = 2'd1; oe_rst_n = 1'b0;
        @(negedge clk);
        check(cascade_n == 1'b1, "R2", "cascade_n released by clear", int'(cascade_n), 1);
        check(dout_oe == 1'b0, "R2", "dout_oe during clear", int'(dout_oe), 0);
        oe_rst_n = 1'b1;
        cur_req = "R3";
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(dout_oe == 1'b0, "R3", "dout_oe with chip disabled", int'(dout_oe), 0);
        end
        ce_n = 1'b0;
        cur_req = "R2";
        q.delete();
        collect(q, 100);
        compare_stream(q, Q, Q, "R2");

        // R3: pause in the middle of page 3
        cur_req = "R3"; page_sel = 2'd3; oe_rst_n = 1'b0;
        @(negedge clk);
        oe_rst_n = 1'b1;
        q.delete();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (dout_oe) q.push_back(dout);
        end
        ce_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(dout_oe == 1'b0, "R3", "dout_oe while paused", int'(dout_oe), 0);
        end
        ce_n = 1'b0;
        collect(q, 100);
        compare_stream(q, 3 * Q, Q, "R3");

        // R8: clear in programming mode ignores page request
        cur_req = "R8"; ser_en = 1'b0; page_en = 1'b1; page_sel = 2'd3; oe_rst_n = 1'b0;
        @(negedge clk);
        oe_rst_n = 1'b1; ce_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(dout_oe == 1'b0, "R8", "dout_oe in programming mode", int'(dout_oe), 0);
        end
        ser_en = 1'b1;
        q.delete();
        collect(q, 200);
        compare_stream(q, 0, DEPTH, "R8");

        summary();
    end

endmodule